// File: doc/BRIEF.md
# Receive Status Ring Writer

This block manages the receive side of a descriptor-ring network DMA engine. Two rings live in system memory: one holds free receive descriptors, the other collects per-frame completion records. The block keeps one credit count for each ring. Software returns entries to a ring by writing a count to that ring's enqueue select. The hardware keeps a current address for each ring, and that address advances on its own.

When the receive path reports a finished frame, the block checks both credit counts. If both are non-zero, it takes one descriptor and one status slot, builds a two-word completion record and writes it through a simple valid/ready memory write port at the status ring's current address. It then steps that address forward, wrapping at the end of the ring. If either credit count is zero, the frame is discarded and a drop counter goes up.

Top module: `rxq_status_writer`

## Requirements
- R1: After reset both credit counts, the drop counter and both current addresses read zero, `mem_wvalid` is low and `frm_ready` is high.
- R2: A configuration write with `cfg_sel` 2 adds `cfg_wdata` to the descriptor credit count, and one with `cfg_sel` 5 adds it to the status credit count.
- R3: A frame accepted while both credit counts are non-zero lowers each count by one.
- R4: A frame accepted while either credit count is zero raises `drop_cnt` by one, produces no memory write, and leaves both credit counts unchanged.
- R5: A status record is written as word 0 at the status current address, then word 1 at that address plus 4. Address and data hold steady while `mem_wready` is low.
- R6: Word 0 always has bits 31, 29 and 28 set. `frm_err` bits 4..0 (overrun, framing, runt, extra data, CRC error) map to bits 20..16, and `frm_crc_incl` maps to bit 15.
- R7: Word 0 bit 30 (clean frame) is set only when bits 20..16 of word 0 are all clear. The CRC-included flag does not affect it.
- R8: A frame longer than MAX_LEN (2044) bytes gets the extra-data bit (bit 17) set, which also clears bit 30.
- R9: Word 1 has bit 31 set, bits 30:16 holding the index of the descriptor used (its byte offset from the descriptor base divided by 8), and bits 15:0 holding the frame length.
- R10: The status current address moves forward by 8 only after word 1 is accepted. It returns to the status base when it reaches base plus length.
- R11: The descriptor current address moves forward by 8 for every frame that is not dropped, and wraps to its base in the same way.
- R12: Writing a ring's base address (`cfg_sel` 0 for descriptors, 3 for status) also sets that ring's current address to the new base. `cfg_sel` 1 and 4 set the ring byte lengths.
- R13: `frm_ready` is low from frame acceptance until word 1 of its record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_wdata | input | AW | Configuration write value |
| frm_valid | input | 1 | Finished-frame report valid |
| frm_ready | output | 1 | Block can take a frame report |
| frm_len | input | 16 | Frame length in bytes |
| frm_err | input | 5 | Error flags: overrun, framing, runt, extra data, CRC |
| frm_crc_incl | input | 1 | Length includes the CRC |
| mem_wvalid | output | 1 | Memory write request |
| mem_wready | input | 1 | Memory write accepted |
| mem_waddr | output | AW | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| desc_cur | output | AW | Descriptor ring current address |
| stat_cur | output | AW | Status ring current address |
| desc_credit | output | CREDIT_W | Free descriptor count |
| stat_credit | output | CREDIT_W | Free status slot count |
| drop_cnt | output | DROP_W | Dropped frame count |

## Verification
The bench builds the block with CREDIT_W=6 and leaves AW, MAX_LEN and DROP_W at their defaults. Because MAX_LEN stays at 2044, frames of 2044 and 2045 bytes fall on either side of the length limit. The ring lengths are set through the configuration port to three descriptor slots and two status slots. This lets a handful of frames reach both wrap points and both kinds of credit starvation.

// File: rtl/rxq_pkg.sv
// Shared encodings for the receive status ring writer.
// Assumes 32-bit status words with fixed field positions.
package rxq_pkg;
    localparam int FLEN_W    = 16;
    localparam int IDX_W     = 15;
    localparam int ERR_W     = 5;
    localparam int WORD_W    = 32;
    localparam int SLOT_SH   = 3;

    typedef enum logic [2:0] {
        SEL_DESC_BASE = 3'd0,
        SEL_DESC_LEN  = 3'd1,
        SEL_DESC_ENQ  = 3'd2,
        SEL_STAT_BASE = 3'd3,
        SEL_STAT_LEN  = 3'd4,
        SEL_STAT_ENQ  = 3'd5
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WORD0 = 2'd1,
        ST_WORD1 = 2'd2
    } wr_state_e;
endpackage

// File: rtl/rxq_credit.sv
// Free-entry credit counter for one ring.
// Software adds a count; hardware takes one per consumed entry.
// Assumes the caller never takes while the count is zero.
module rxq_credit #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [CW-1:0] add_val,
    input  logic          take,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [CW-1:0] add_term;
    logic [CW-1:0] take_term;

    // Select the terms that apply this cycle.
    always_comb begin
        add_term  = add_en ? add_val : '0;
        take_term = take ? CW'(1) : '0;
    end

    // Update the count by enqueue minus consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + add_term - take_term;
    end

    assign empty = (count == '0);

    // R3
    credit_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (count != '0));
endmodule

// File: rtl/rxq_ring_ptr.sv
// Base, length and current-address registers for one ring.
// The current address steps by STEP bytes and wraps to base at base+len.
// A base write also reloads the current address.
module rxq_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic          len_we,
    input  logic [AW-1:0] wdata,
    input  logic          advance,
    output logic [AW-1:0] base,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] len_q;
    logic [AW-1:0] stepped;
    logic [AW-1:0] limit;

    // Compute the next slot address and the ring end.
    always_comb begin
        stepped = cur + AW'(STEP);
        limit   = base + len_q;
    end

    // Hold the programmed base and byte length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            len_q <= '0;
        end else begin
            if (base_we) base  <= wdata;
            if (len_we)  len_q <= wdata;
        end
    end

    // Move the current address: reload, step or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                cur <= '0;
        else if (base_we)          cur <= wdata;
        else if (advance) begin
            if (stepped >= limit)  cur <= base;
            else                   cur <= stepped;
        end
    end

    // R10 R11
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !base_we && !len_we) |=>
            ((cur == base) || (cur == $past(cur) + AW'(STEP))));

    // R12
    base_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (cur == base));
endmodule

// File: rtl/rxq_stat_enc.sv
// Builds the two status words for one received frame.
// Purely combinational; field positions are fixed by the ring format.
module rxq_stat_enc
    import rxq_pkg::*;
#(
    parameter int MAX_LEN = 2044
) (
    input  logic [FLEN_W-1:0] len,
    input  logic [ERR_W-1:0]  err,
    input  logic              crc_incl,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1
);
    logic              too_long;
    logic [ERR_W-1:0]  err_all;

    // Fold the length limit into the extra-data flag.
    always_comb begin
        too_long   = (int'(len) > MAX_LEN);
        err_all    = err;
        err_all[1] = err[1] | too_long;
    end

    // Pack word 0: done, clean, end-of-frame, end-of-buffer, errors.
    always_comb begin
        word0        = '0;
        word0[31]    = 1'b1;
        word0[30]    = (err_all == '0);
        word0[29]    = 1'b1;
        word0[28]    = 1'b1;
        word0[20:16] = err_all;
        word0[15]    = crc_incl;
    end

    // Pack word 1: done, descriptor index, frame length.
    always_comb begin
        word1 = {1'b1, idx, len};
    end
endmodule

// File: rtl/rxq_status_writer.sv
// Receive status ring writer.
// Tracks descriptor and status credits, accepts finished-frame reports,
// and writes a two-word status record per frame to the status ring.
// Assumes the memory port keeps no state between requests and that
// software does not reprogram a ring while records are in flight.
module rxq_status_writer
    import rxq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CREDIT_W = 8,
    parameter int MAX_LEN  = 2044,
    parameter int DROP_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [AW-1:0]       cfg_wdata,
    input  logic                frm_valid,
    output logic                frm_ready,
    input  logic [FLEN_W-1:0]   frm_len,
    input  logic [ERR_W-1:0]    frm_err,
    input  logic                frm_crc_incl,
    output logic                mem_wvalid,
    input  logic                mem_wready,
    output logic [AW-1:0]       mem_waddr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [AW-1:0]       desc_cur,
    output logic [AW-1:0]       stat_cur,
    output logic [CREDIT_W-1:0] desc_credit,
    output logic [CREDIT_W-1:0] stat_credit,
    output logic [DROP_W-1:0]   drop_cnt
);
    localparam int SLOT_BYTES = 1 << SLOT_SH;

    wr_state_e         state;
    logic              desc_empty, stat_empty, have_credit;
    logic              frm_acc, take, drop;
    logic [AW-1:0]     desc_base, stat_base, desc_off;
    logic [IDX_W-1:0]  desc_idx;
    logic [WORD_W-1:0] enc_w0, enc_w1, w0_q, w1_q;
    logic [AW-1:0]     addr_q;
    logic              stat_adv;
    logic              sel_dbase, sel_dlen, sel_denq;
    logic              sel_sbase, sel_slen, sel_senq;

    // Decode configuration writes.
    always_comb begin
        sel_dbase = cfg_we && (cfg_sel == SEL_DESC_BASE);
        sel_dlen  = cfg_we && (cfg_sel == SEL_DESC_LEN);
        sel_denq  = cfg_we && (cfg_sel == SEL_DESC_ENQ);
        sel_sbase = cfg_we && (cfg_sel == SEL_STAT_BASE);
        sel_slen  = cfg_we && (cfg_sel == SEL_STAT_LEN);
        sel_senq  = cfg_we && (cfg_sel == SEL_STAT_ENQ);
    end

    // Frame acceptance and the keep/drop decision.
    always_comb begin
        frm_ready   = (state == ST_IDLE);
        have_credit = !desc_empty && !stat_empty;
        frm_acc     = frm_valid && frm_ready;
        take        = frm_acc && have_credit;
        drop        = frm_acc && !have_credit;
        stat_adv    = (state == ST_WORD1) && mem_wready;
    end

    // Descriptor index from its offset within the ring.
    always_comb begin
        desc_off = desc_cur - desc_base;
        desc_idx = desc_off[SLOT_SH +: IDX_W];
    end

    rxq_credit #(.CW(CREDIT_W)) u_desc_credit (
        .clk(clk), .rst_n(rst_n),
        .add_en(sel_denq), .add_val(cfg_wdata[CREDIT_W-1:0]),
        .take(take), .count(desc_credit), .empty(desc_empty)
    );

    rxq_credit #(.CW(CREDIT_W)) u_stat_credit (
        .clk(clk), .rst_n(rst_n),
        .add_en(sel_senq), .add_val(cfg_wdata[CREDIT_W-1:0]),
        .take(take), .count(stat_credit), .empty(stat_empty)
    );

    rxq_ring_ptr #(.AW(AW), .STEP(SLOT_BYTES)) u_desc_ring (
        .clk(clk), .rst_n(rst_n),
        .base_we(sel_dbase), .len_we(sel_dlen), .wdata(cfg_wdata),
        .advance(take), .base(desc_base), .cur(desc_cur)
    );

    rxq_ring_ptr #(.AW(AW), .STEP(SLOT_BYTES)) u_stat_ring (
        .clk(clk), .rst_n(rst_n),
        .base_we(sel_sbase), .len_we(sel_slen), .wdata(cfg_wdata),
        .advance(stat_adv), .base(stat_base), .cur(stat_cur)
    );

    rxq_stat_enc #(.MAX_LEN(MAX_LEN)) u_enc (
        .len(frm_len), .err(frm_err), .crc_incl(frm_crc_incl),
        .idx(desc_idx), .word0(enc_w0), .word1(enc_w1)
    );

    // Sequence the two word writes of one record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            w0_q  <= '0;
            w1_q  <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    state  <= ST_WORD0;
                    w0_q   <= enc_w0;
                    w1_q   <= enc_w1;
                    addr_q <= stat_cur;
                end
                ST_WORD0: if (mem_wready) state <= ST_WORD1;
                ST_WORD1: if (mem_wready) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Count frames discarded for lack of credit.
    always_ff @(posedge clk) begin
        if (!rst_n)    drop_cnt <= '0;
        else if (drop) drop_cnt <= drop_cnt + DROP_W'(1);
    end

    // Drive the memory write port from the latched record.
    always_comb begin
        mem_wvalid = (state != ST_IDLE);
        mem_waddr  = (state == ST_WORD1) ? addr_q + AW'(4) : addr_q;
        mem_wdata  = (state == ST_WORD1) ? w1_q : w0_q;
    end

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=>
            (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    // R4
    drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (!mem_wvalid && (drop_cnt == $past(drop_cnt) + DROP_W'(1))));

    // R13
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> !frm_ready);

    // R7
    clean_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && (state == ST_WORD0) && mem_wdata[30]) |->
            (mem_wdata[20:16] == '0));
endmodule

// File: tb/sim_rxq_status_writer.sv
module sim_rxq_status_writer;
    localparam int AW = 32;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          frm_valid = 1'b0;
    logic          frm_ready;
    logic [15:0]   frm_len = '0;
    logic [4:0]    frm_err = '0;
    logic          frm_crc_incl = 1'b0;
    logic          mem_wvalid;
    logic          mem_wready = 1'b0;
    logic [AW-1:0] mem_waddr;
    logic [31:0]   mem_wdata;
    logic [AW-1:0] desc_cur, stat_cur;
    logic [CW-1:0] desc_credit, stat_credit;
    logic [15:0]   drop_cnt;

    int tot = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rxq_status_writer #(.AW(AW), .CREDIT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_len(frm_len), .frm_err(frm_err), .frm_crc_incl(frm_crc_incl),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .desc_cur(desc_cur), .stat_cur(stat_cur),
        .desc_credit(desc_credit), .stat_credit(stat_credit),
        .drop_cnt(drop_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tot++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Reset state (R1).
    task automatic t_reset();
        chk("R1 desc_credit", 32'(desc_credit), 0);
        chk("R1 stat_credit", 32'(stat_credit), 0);
        chk("R1 drop_cnt", 32'(drop_cnt), 0);
        chk("R1 desc_cur", desc_cur, 0);
        chk("R1 stat_cur", stat_cur, 0);
        chk("R1 mem_wvalid", 32'(mem_wvalid), 0);
        chk("R1 frm_ready", 32'(frm_ready), 1);
    endtask

    // Ring programming (R12).
    task automatic t_setup();
        cfg(3'd0, 32'h1000);
        cfg(3'd1, 32'd24);
        cfg(3'd3, 32'h2000);
        cfg(3'd4, 32'd16);
        chk("R12 desc_cur at base", desc_cur, 32'h1000);
        chk("R12 stat_cur at base", stat_cur, 32'h2000);
    endtask

    // Frame that must be dropped (R4).
    task automatic t_drop(input int exp_drop, input int exp_dc, input int exp_sc);
        @(negedge clk);
        frm_valid = 1'b1; frm_len = 16'd60; frm_err = '0; frm_crc_incl = 1'b0;
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R4 no write", 32'(mem_wvalid), 0);
        chk("R4 drop_cnt", 32'(drop_cnt), 32'(exp_drop));
        chk("R4 desc credit kept", 32'(desc_credit), 32'(exp_dc));
        chk("R4 stat credit kept", 32'(stat_credit), 32'(exp_sc));
        chk("R13 ready after drop", 32'(frm_ready), 1);
    endtask

    // Frame that produces a status record (R3 R5 R6 R9 R10 R11 R13).
    task automatic t_frame(input logic [15:0] len, input logic [4:0] err, input logic crc,
                           input int stall, input logic [31:0] ew0, input logic [31:0] ew1,
                           input logic [31:0] ea, input int exp_dc, input int exp_sc);
        @(negedge clk);
        frm_valid = 1'b1; frm_len = len; frm_err = err; frm_crc_incl = crc;
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R13 busy not ready", 32'(frm_ready), 0);
        chk("R3 desc credit", 32'(desc_credit), 32'(exp_dc));
        chk("R3 stat credit", 32'(stat_credit), 32'(exp_sc));
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < stall; s++) begin
                chk("R5 held valid", 32'(mem_wvalid), 1);
                chk("R5 held addr", mem_waddr, ea + 32'(4 * w));
                chk("R5 held data", mem_wdata, (w == 0) ? ew0 : ew1);
                @(negedge clk);
            end
            chk("R5 valid", 32'(mem_wvalid), 1);
            chk("R5 addr", mem_waddr, ea + 32'(4 * w));
            chk((w == 0) ? "R6 word0" : "R9 word1", mem_wdata, (w == 0) ? ew0 : ew1);
            if (w == 0) chk("R10 no advance before word1", stat_cur, ea);
            mem_wready = 1'b1;
            @(negedge clk);
            mem_wready = 1'b0;
        end
        chk("R13 ready after record", 32'(frm_ready), 1);
        chk("R5 idle after record", 32'(mem_wvalid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        // Both credits zero.
        t_drop(1, 0, 0);
        // Descriptors returned but no status slots (R2, R4).
        cfg(3'd2, 32'd2);
        chk("R2 desc enqueue", 32'(desc_credit), 2);
        t_drop(2, 2, 0);
        cfg(3'd2, 32'd3);
        cfg(3'd5, 32'd4);
        chk("R2 desc enqueue adds", 32'(desc_credit), 5);
        chk("R2 stat enqueue", 32'(stat_credit), 4);
        // Clean frame, no stall.
        t_frame(16'd64, 5'b00000, 1'b0, 0, 32'hF000_0000, 32'h8000_0040, 32'h2000, 4, 3);
        chk("R10 stat step", stat_cur, 32'h2008);
        chk("R11 desc step", desc_cur, 32'h1008);
        // Overrun and CRC error with CRC included, stalled writes.
        t_frame(16'd100, 5'b10001, 1'b1, 2, 32'hB011_8000, 32'h8001_0064, 32'h2008, 3, 2);
        chk("R10 stat wrap", stat_cur, 32'h2000);
        // One byte over the limit (R8).
        t_frame(16'd2045, 5'b00000, 1'b0, 1, 32'hB002_0000, 32'h8002_07FD, 32'h2000, 2, 1);
        chk("R11 desc wrap", desc_cur, 32'h1000);
        // At the limit with CRC included: still clean (R7 R8).
        t_frame(16'd2044, 5'b00000, 1'b1, 0, 32'hF000_8000, 32'h8000_07FC, 32'h2008, 1, 0);
        chk("R10 stat wrap again", stat_cur, 32'h2000);
        chk("R11 desc after four", desc_cur, 32'h1008);
        // Status slots exhausted.
        t_drop(3, 1, 0);
        chk("R11 desc kept on drop", desc_cur, 32'h1008);
        // Base rewrite reloads current address.
        cfg(3'd3, 32'h3000);
        chk("R12 stat reload", stat_cur, 32'h3000);
        $display("  test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end
endmodule